// File: doc/BRIEF.md
# Two-Channel Memory Copy Engine

The block moves data from one region of memory to another on behalf of software. It has two independent channels. Each channel is given an initial source address, an initial destination address, an element count and a packed control word. When a start command arrives, the channel copies `count` elements. For each element it reads from the source, writes to the destination, decrements its count and then steps each address by the element size, or holds an address that is configured as fixed. The current source, destination and count are visible on ports at all times.

Both channels share one single-master memory port. A fixed-priority arbiter hands that port to the lowest-numbered requesting channel and keeps the grant until the burst length set in the owner's control word is used up or the owner stops requesting. A channel finishes by raising its completion flag if interrupts are enabled, or, in auto-reload mode, by reloading its initial values and continuing. A bus error stops the channel and records the failing address and whether it was a read or a write.

Each channel runs a state machine with three states: `CH_IDLE`, `CH_RUN` and `CH_PAUSE`. Its transitions are:
- start (`CH_IDLE`→`CH_RUN`, nonzero count only)
- pause (`CH_RUN`→`CH_PAUSE`)
- resume (`CH_PAUSE`→`CH_RUN`)
- cancel, error and final element without reload (`CH_RUN`/`CH_PAUSE`→`CH_IDLE`)

The shared mover steps through `MV_IDLE`→`MV_READ`→`MV_WRITE`→`MV_FIN`→`MV_IDLE`. A read error jumps from `MV_READ` straight to `MV_FIN`.

Top module: `dma2_engine`

## Requirements
- R1: After reset, `busy`, `done_irq`, `err_irq` and `mem_req` are all 0.
- R2: A channel is started by a pulse on `cmd_wr[i]` with command field ctrl[1:0] = 1; the command codes are 0 none, 1 start, 2 pause, 3 cancel. The channel then copies `init_cnt` elements from `init_src` to `init_dst`, reading each element before writing it. `cur_src`, `cur_dst` and `cur_cnt` track progress, and `cur_cnt` is 0 at the end.
- R3: Width field ctrl[3:2] selects 0 byte, 1 halfword or 2 word, giving address steps of 1, 2 and 4 bytes. `mem_size` carries the same code. The reserved code 3 behaves as word, and `mem_size` reports 2 for it.
- R4: ctrl[6] (source) and ctrl[7] (destination) set the address mode: 0 advances the address by the element size, 1 keeps it fixed.
- R5: A pause command (code 2) halts the channel at an element boundary. While paused, the current values stay unchanged and `busy` stays 1. A later start command resumes from the current values and does not reload the initial ones.
- R6: A cancel command (code 3) returns the channel to idle and clears `busy`. The completion flag is not raised.
- R7: `done_irq[i]` is set when the final element completes, but only if ctrl[9] is 1. It is cleared by a pulse on `irq_clr[i]`.
- R8: With ctrl[8] = 1, completing the last element reloads the initial source, destination and count. The channel keeps running, with `busy` held at 1.
- R9: If `mem_err` is returned with `mem_ack`, the channel stops and sets `err_irq[i]`. It records the failing address in `err_addr[i]` and the direction in `err_dir[i]` (0 read, 1 write). The failed element is not counted. `irq_clr[i]` clears `err_irq[i]`.
- R10: Channel 0 wins when both channels request. A grant is held for 1, 4, 8 or 16 elements (burst field ctrl[5:4] = 0..3) and is not taken away mid-burst.
- R11: A start command with `init_cnt` = 0 is ignored. The channel stays idle and issues no bus access.
- R12: Once `mem_req` is raised, it stays high with the same address and direction until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | NCH | Per-channel strobe that executes the command in `ctrl` |
| ctrl | input | NCH x 10 | Per-channel control word {int_en, reload, dst_fixed, src_fixed, burst[1:0], width[1:0], cmd[1:0]} |
| init_src | input | NCH x AW | Initial source address |
| init_dst | input | NCH x AW | Initial destination address |
| init_cnt | input | NCH x CW | Initial element count |
| irq_clr | input | NCH | Write-to-clear strobe for completion and error flags |
| busy | output | NCH | Channel running or paused |
| done_irq | output | NCH | Completion flag |
| err_irq | output | NCH | Bus error flag |
| err_addr | output | NCH x AW | Captured failing address |
| err_dir | output | NCH | Captured direction, 0 read, 1 write |
| cur_src | output | NCH x AW | Current source address |
| cur_dst | output | NCH x AW | Current destination address |
| cur_cnt | output | NCH x CW | Remaining element count |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Byte address |
| mem_size | output | 2 | Access size code (0 byte, 1 half, 2 word) |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Access failed, valid with `mem_ack` |

## Verification
Assertions check four things on every cycle:
- the bus request stays steady until it is acknowledged;
- a paused channel's current values do not move;
- a cancel always leaves the channel idle;
- the completion flag rises only right after a final element completes with interrupts enabled.

The arbiter also asserts that a granted burst keeps its owner until the burst ends. The directed scenarios are the only way to show the rest:
- the copied data itself;
- the address stepping for each width and address mode;
- the order in which two competing channels appear on the bus;
- the recorded error address and direction;
- the address pattern after an auto-reload;
- a resume that continues rather than restarts.

// File: rtl/dma2_pkg.sv
package dma2_pkg;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_START  = 2'd1,
        CMD_PAUSE  = 2'd2,
        CMD_CANCEL = 2'd3
    } cmd_e;

    typedef struct packed {
        logic       int_en;
        logic       reload;
        logic       dst_fixed;
        logic       src_fixed;
        logic [1:0] burst;
        logic [1:0] width;
        cmd_e       cmd;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int BEAT_W = 4;

    // byte step for an element width code; reserved code acts as word
    function automatic logic [2:0] step_of(input logic [1:0] w);
        logic [2:0] s;
        unique case (w)
            2'd0:    s = 3'd1;
            2'd1:    s = 3'd2;
            default: s = 3'd4;
        endcase
        return s;
    endfunction

    // burst code to (beats - 1)
    function automatic logic [BEAT_W-1:0] beats_m1(input logic [1:0] b);
        logic [BEAT_W-1:0] n;
        unique case (b)
            2'd0:    n = 4'd0;
            2'd1:    n = 4'd3;
            2'd2:    n = 4'd7;
            default: n = 4'd15;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/dma2_channel.sv
module dma2_channel
    import dma2_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  ctrl_t         ctrl,
    input  logic [AW-1:0] init_src,
    input  logic [AW-1:0] init_dst,
    input  logic [CW-1:0] init_cnt,
    input  logic          irq_clr,
    input  logic          upd,
    input  logic          upd_err,
    input  logic          upd_dir,
    input  logic [AW-1:0] upd_addr,
    output logic          req,
    output logic          busy,
    output logic [AW-1:0] cur_src,
    output logic [AW-1:0] cur_dst,
    output logic [CW-1:0] cur_cnt,
    output logic [1:0]    width,
    output logic [1:0]    burst,
    output logic          done_irq,
    output logic          err_irq,
    output logic [AW-1:0] err_addr,
    output logic          err_dir
);

    typedef enum logic [1:0] {CH_IDLE, CH_RUN, CH_PAUSE} ch_state_e;

    ch_state_e st, st_nxt;
    logic      m_int_en, m_reload, m_src_fix, m_dst_fix;
    logic [1:0] m_width, m_burst;
    cmd_e      cmd_now;
    logic      last, fin, bad, rl_ok, live;
    logic [AW-1:0] step;

    assign cmd_now = cmd_wr ? ctrl.cmd : CMD_NONE;
    assign live    = (st != CH_IDLE);
    assign last    = (cur_cnt == CW'(1));
    assign fin     = live && upd && !upd_err && last;
    assign bad     = live && upd && upd_err;
    assign rl_ok   = m_reload && (init_cnt != '0);
    assign step    = AW'(step_of(m_width));

    always_comb begin
        st_nxt = st;
        unique case (st)
            CH_IDLE: begin
                if (cmd_now == CMD_START && init_cnt != '0)
                    st_nxt = CH_RUN;
            end
            CH_RUN: begin
                if (bad || (fin && !rl_ok) || cmd_now == CMD_CANCEL)
                    st_nxt = CH_IDLE;
                else if (cmd_now == CMD_PAUSE)
                    st_nxt = CH_PAUSE;
            end
            CH_PAUSE: begin
                if (bad || (fin && !rl_ok) || cmd_now == CMD_CANCEL)
                    st_nxt = CH_IDLE;
                else if (cmd_now == CMD_START)
                    st_nxt = CH_RUN;
            end
            default: st_nxt = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= CH_IDLE;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_src   <= '0;
            cur_dst   <= '0;
            cur_cnt   <= '0;
            m_int_en  <= 1'b0;
            m_reload  <= 1'b0;
            m_src_fix <= 1'b0;
            m_dst_fix <= 1'b0;
            m_width   <= 2'd0;
            m_burst   <= 2'd0;
            done_irq  <= 1'b0;
            err_irq   <= 1'b0;
            err_addr  <= '0;
            err_dir   <= 1'b0;
        end else begin
            if (st == CH_IDLE && st_nxt == CH_RUN) begin
                cur_src   <= init_src;
                cur_dst   <= init_dst;
                cur_cnt   <= init_cnt;
                m_int_en  <= ctrl.int_en;
                m_reload  <= ctrl.reload;
                m_src_fix <= ctrl.src_fixed;
                m_dst_fix <= ctrl.dst_fixed;
                m_width   <= ctrl.width;
                m_burst   <= ctrl.burst;
            end else if (live && upd && !upd_err) begin
                if (last && rl_ok) begin
                    cur_src <= init_src;
                    cur_dst <= init_dst;
                    cur_cnt <= init_cnt;
                end else begin
                    cur_cnt <= cur_cnt - CW'(1);
                    if (!m_src_fix) cur_src <= cur_src + step;
                    if (!m_dst_fix) cur_dst <= cur_dst + step;
                end
            end
            done_irq <= (fin && m_int_en) || (done_irq && !irq_clr);
            err_irq  <= bad || (err_irq && !irq_clr);
            if (bad) begin
                err_addr <= upd_addr;
                err_dir  <= upd_dir;
            end
        end
    end

    always_comb begin
        req   = (st == CH_RUN);
        busy  = live;
        width = m_width;
        burst = m_burst;
    end

    // R5
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_PAUSE && !upd && cmd_now == CMD_NONE)
        |=> ($stable(cur_cnt) && $stable(cur_src) && $stable(cur_dst)));

    // R6
    cancel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && cmd_now == CMD_CANCEL) |=> !busy);

    // R7
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_irq) |-> $past(upd && !upd_err && last && m_int_en));

endmodule

// File: rtl/dma2_arbiter.sv
module dma2_arbiter
    import dma2_pkg::*;
#(
    parameter int NCH = 2,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       req,
    input  logic [NCH-1:0]       done,
    input  logic [NCH-1:0][1:0]  burst,
    output logic                 gnt_valid,
    output logic [IW-1:0]        owner
);

    logic [BEAT_W-1:0] beat;
    logic [IW-1:0]     pick;
    logic              last_beat;

    always_comb begin
        pick = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) pick = IW'(i);
        end
    end

    assign last_beat = (beat == beats_m1(burst[owner]));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gnt_valid <= 1'b0;
            owner     <= '0;
            beat      <= '0;
        end else if (!gnt_valid) begin
            if (|req) begin
                gnt_valid <= 1'b1;
                owner     <= pick;
                beat      <= '0;
            end
        end else if (done[owner]) begin
            if (last_beat) gnt_valid <= 1'b0;
            else           beat      <= beat + BEAT_W'(1);
        end else if (!req[owner]) begin
            gnt_valid <= 1'b0;
        end
    end

    // R10
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && req[owner] && !(done[owner] && last_beat))
        |=> (gnt_valid && $stable(owner)));

endmodule

// File: rtl/dma2_mover.sv
module dma2_mover #(
    parameter int NCH = 2,
    parameter int AW  = 32,
    parameter int DW  = 32,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 gnt_valid,
    input  logic [IW-1:0]        owner,
    input  logic [NCH-1:0]       req,
    input  logic [NCH-1:0][AW-1:0] src,
    input  logic [NCH-1:0][AW-1:0] dst,
    input  logic [NCH-1:0][1:0]  width,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [AW-1:0]        mem_addr,
    output logic [1:0]           mem_size,
    output logic [DW-1:0]        mem_wdata,
    input  logic [DW-1:0]        mem_rdata,
    input  logic                 mem_ack,
    input  logic                 mem_err,
    output logic [NCH-1:0]       done,
    output logic                 done_err,
    output logic                 done_dir,
    output logic [AW-1:0]        done_addr
);

    typedef enum logic [1:0] {MV_IDLE, MV_READ, MV_WRITE, MV_FIN} mv_state_e;

    mv_state_e     st, st_nxt;
    logic          go;
    logic [IW-1:0] ch;
    logic [AW-1:0] a_src, a_dst;
    logic [1:0]    sz;
    logic [DW-1:0] data;

    assign go = gnt_valid && req[owner];

    always_comb begin
        st_nxt = st;
        unique case (st)
            MV_IDLE:  if (go) st_nxt = MV_READ;
            MV_READ:  if (mem_ack) st_nxt = mem_err ? MV_FIN : MV_WRITE;
            MV_WRITE: if (mem_ack) st_nxt = MV_FIN;
            MV_FIN:   st_nxt = MV_IDLE;
            default:  st_nxt = MV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= MV_IDLE;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch        <= '0;
            a_src     <= '0;
            a_dst     <= '0;
            sz        <= 2'd0;
            data      <= '0;
            done_err  <= 1'b0;
            done_dir  <= 1'b0;
            done_addr <= '0;
        end else begin
            if (st == MV_IDLE && go) begin
                ch       <= owner;
                a_src    <= src[owner];
                a_dst    <= dst[owner];
                sz       <= (width[owner] == 2'd3) ? 2'd2 : width[owner];
                done_err <= 1'b0;
            end
            if (st == MV_READ && mem_ack) begin
                data      <= mem_rdata;
                done_err  <= mem_err;
                done_dir  <= 1'b0;
                done_addr <= a_src;
            end
            if (st == MV_WRITE && mem_ack) begin
                done_err  <= mem_err;
                done_dir  <= 1'b1;
                done_addr <= a_dst;
            end
        end
    end

    always_comb begin
        mem_req   = (st == MV_READ) || (st == MV_WRITE);
        mem_we    = (st == MV_WRITE);
        mem_addr  = (st == MV_WRITE) ? a_dst : a_src;
        mem_size  = sz;
        mem_wdata = data;
        done      = '0;
        if (st == MV_FIN) done[ch] = 1'b1;
    end

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R2
    single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done));

endmodule

// File: rtl/dma2_engine.sv
module dma2_engine
    import dma2_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 32,
    parameter int CW  = 16,
    parameter int DW  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCH-1:0]           cmd_wr,
    input  logic [NCH-1:0][CTRL_W-1:0] ctrl,
    input  logic [NCH-1:0][AW-1:0]   init_src,
    input  logic [NCH-1:0][AW-1:0]   init_dst,
    input  logic [NCH-1:0][CW-1:0]   init_cnt,
    input  logic [NCH-1:0]           irq_clr,
    output logic [NCH-1:0]           busy,
    output logic [NCH-1:0]           done_irq,
    output logic [NCH-1:0]           err_irq,
    output logic [NCH-1:0][AW-1:0]   err_addr,
    output logic [NCH-1:0]           err_dir,
    output logic [NCH-1:0][AW-1:0]   cur_src,
    output logic [NCH-1:0][AW-1:0]   cur_dst,
    output logic [NCH-1:0][CW-1:0]   cur_cnt,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [AW-1:0]            mem_addr,
    output logic [1:0]               mem_size,
    output logic [DW-1:0]            mem_wdata,
    input  logic [DW-1:0]            mem_rdata,
    input  logic                     mem_ack,
    input  logic                     mem_err
);

    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

    logic [NCH-1:0]      req, done;
    logic [NCH-1:0][1:0] width, burst;
    logic                gnt_valid;
    logic [IW-1:0]       owner;
    logic                done_err, done_dir;
    logic [AW-1:0]       done_addr;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        dma2_channel #(.AW(AW), .CW(CW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd_wr   (cmd_wr[i]),
            .ctrl     (ctrl_t'(ctrl[i])),
            .init_src (init_src[i]),
            .init_dst (init_dst[i]),
            .init_cnt (init_cnt[i]),
            .irq_clr  (irq_clr[i]),
            .upd      (done[i]),
            .upd_err  (done_err),
            .upd_dir  (done_dir),
            .upd_addr (done_addr),
            .req      (req[i]),
            .busy     (busy[i]),
            .cur_src  (cur_src[i]),
            .cur_dst  (cur_dst[i]),
            .cur_cnt  (cur_cnt[i]),
            .width    (width[i]),
            .burst    (burst[i]),
            .done_irq (done_irq[i]),
            .err_irq  (err_irq[i]),
            .err_addr (err_addr[i]),
            .err_dir  (err_dir[i])
        );
    end

    dma2_arbiter #(.NCH(NCH)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .done      (done),
        .burst     (burst),
        .gnt_valid (gnt_valid),
        .owner     (owner)
    );

    dma2_mover #(.NCH(NCH), .AW(AW), .DW(DW)) u_mv (
        .clk       (clk),
        .rst_n     (rst_n),
        .gnt_valid (gnt_valid),
        .owner     (owner),
        .req       (req),
        .src       (cur_src),
        .dst       (cur_dst),
        .width     (width),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_size  (mem_size),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .mem_err   (mem_err),
        .done      (done),
        .done_err  (done_err),
        .done_dir  (done_dir),
        .done_addr (done_addr)
    );

endmodule

// File: tb/tb_dma2_engine.sv
module tb_dma2_engine;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [1:0]        cmd_wr = '0;
    logic [1:0][9:0]   ctrl = '0;
    logic [1:0][31:0]  init_src = '0, init_dst = '0;
    logic [1:0][15:0]  init_cnt = '0;
    logic [1:0]        irq_clr = '0;
    logic [1:0]        busy, done_irq, err_irq, err_dir;
    logic [1:0][31:0]  err_addr, cur_src, cur_dst;
    logic [1:0][15:0]  cur_cnt;
    logic              mem_req, mem_we, mem_ack, mem_err;
    logic [31:0]       mem_addr, mem_wdata, mem_rdata;
    logic [1:0]        mem_size;

    dma2_engine dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .ctrl(ctrl),
        .init_src(init_src), .init_dst(init_dst), .init_cnt(init_cnt),
        .irq_clr(irq_clr), .busy(busy), .done_irq(done_irq),
        .err_irq(err_irq), .err_addr(err_addr), .err_dir(err_dir),
        .cur_src(cur_src), .cur_dst(cur_dst), .cur_cnt(cur_cnt),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .mem_err(mem_err)
    );

    // memory model: byte array, one-cycle ack
    logic [7:0] mem [256];
    logic [7:0] log_addr [64];
    int         log_n;
    logic       err_on = 1'b0;
    logic [7:0] err_at = 8'h00;
    int         hs_bad = 0;
    logic       p_req, p_ack;
    logic [31:0] p_addr;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
            mem_rdata <= '0;
            log_n <= 0;
            for (int k = 0; k < 256; k++) mem[k] <= 8'(k * 7 + 3);
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            mem_err <= err_on && (mem_addr[7:0] == err_at);
            if (!mem_we) begin
                for (int k = 0; k < 4; k++)
                    mem_rdata[8*k +: 8] <= mem[8'(mem_addr[7:0] + 8'(k))];
            end else if (!(err_on && mem_addr[7:0] == err_at)) begin
                for (int k = 0; k < 4; k++)
                    if (k < (1 << mem_size))
                        mem[8'(mem_addr[7:0] + 8'(k))] <= mem_wdata[8*k +: 8];
                if (log_n < 64) log_addr[log_n] <= mem_addr[7:0];
                log_n <= log_n + 1;
            end
        end else begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
        end
    end

    // handshake monitor for R12
    always @(posedge clk) begin
        if (rst_n && p_req && !p_ack && (!mem_req || mem_addr != p_addr))
            hs_bad <= hs_bad + 1;
        p_req  <= rst_n && mem_req;
        p_ack  <= mem_ack;
        p_addr <= mem_addr;
    end

    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic setcfg(input int ch, input logic [1:0] c, input logic [31:0] s,
                          input logic [31:0] d, input logic [15:0] n, input logic [1:0] w,
                          input logic [1:0] b, input logic sf, input logic df,
                          input logic rl, input logic ie);
        ctrl[ch]     = {ie, rl, df, sf, b, w, c};
        init_src[ch] = s;
        init_dst[ch] = d;
        init_cnt[ch] = n;
    endtask

    task automatic fire(input logic [1:0] m);
        cmd_wr = m;
        @(negedge clk);
        cmd_wr = '0;
    endtask

    task automatic command(input int ch, input logic [1:0] c);
        ctrl[ch][1:0] = c;
        fire(2'(1 << ch));
    endtask

    task automatic clr(input int ch);
        irq_clr[ch] = 1'b1;
        @(negedge clk);
        irq_clr[ch] = 1'b0;
    endtask

    task automatic wait_idle(input int ch);
        for (int i = 0; i < 3000; i++) begin
            if (!busy[ch]) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_log(input int n);
        for (int i = 0; i < 3000; i++) begin
            if (log_n >= n) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk("R1 busy", busy, 0);
        chk("R1 done_irq", done_irq, 0);
        chk("R1 err_irq", err_irq, 0);
        chk("R1 mem_req", mem_req, 0);
    endtask

    task automatic t_basic;
        int bad = 0;
        setcfg(0, 2'd1, 32'h00, 32'h20, 16'd3, 2'd2, 2'd0, 0, 0, 0, 1);
        fire(2'b01);
        chk("R2 busy after start", busy[0], 1);
        wait_idle(0);
        for (int k = 0; k < 12; k++) if (mem[8'h20 + k] != mem[k]) bad++;
        chk("R2 word copy data", bad, 0);
        chk("R2 cur_cnt end", cur_cnt[0], 0);
        chk("R3 word src step", cur_src[0], 32'h0C);
        chk("R3 word dst step", cur_dst[0], 32'h2C);
        chk("R7 done set", done_irq[0], 1);
        clr(0);
        chk("R7 done cleared", done_irq[0], 0);
    endtask

    task automatic t_widths;
        int bad = 0;
        setcfg(0, 2'd1, 32'h00, 32'h50, 16'd3, 2'd1, 2'd0, 0, 0, 0, 0);
        fire(2'b01);
        wait_idle(0);
        for (int k = 0; k < 6; k++) if (mem[8'h50 + k] != mem[k]) bad++;
        chk("R3 half data", bad, 0);
        chk("R3 half src step", cur_src[0], 32'h06);
        chk("R7 no irq when disabled", done_irq[0], 0);
        setcfg(0, 2'd1, 32'h00, 32'h58, 16'd3, 2'd0, 2'd0, 0, 0, 0, 0);
        fire(2'b01);
        wait_idle(0);
        chk("R3 byte src step", cur_src[0], 32'h03);
        setcfg(0, 2'd1, 32'h00, 32'h60, 16'd2, 2'd3, 2'd0, 0, 0, 0, 0);
        fire(2'b01);
        wait_idle(0);
        bad = 0;
        for (int k = 0; k < 8; k++) if (mem[8'h60 + k] != mem[k]) bad++;
        chk("R3 reserved acts as word data", bad, 0);
        chk("R3 reserved dst step", cur_dst[0], 32'h68);
    endtask

    task automatic t_fixed;
        int bad = 0;
        setcfg(0, 2'd1, 32'h08, 32'h70, 16'd4, 2'd0, 2'd0, 1, 0, 0, 0);
        fire(2'b01);
        wait_idle(0);
        for (int k = 0; k < 4; k++) if (mem[8'h70 + k] != mem[8]) bad++;
        chk("R4 fixed src data", bad, 0);
        chk("R4 fixed src held", cur_src[0], 32'h08);
        chk("R4 dst advanced", cur_dst[0], 32'h74);
        setcfg(0, 2'd1, 32'h00, 32'h78, 16'd3, 2'd0, 2'd0, 0, 1, 0, 0);
        fire(2'b01);
        wait_idle(0);
        chk("R4 fixed dst last data", mem[8'h78], mem[2]);
        chk("R4 fixed dst held", cur_dst[0], 32'h78);
    endtask

    task automatic t_zero;
        setcfg(0, 2'd1, 32'h00, 32'hF0, 16'd0, 2'd0, 2'd0, 0, 0, 0, 1);
        fire(2'b01);
        chk("R11 zero count stays idle", busy[0], 0);
        repeat (3) @(negedge clk);
        chk("R11 no bus access", mem_req, 0);
    endtask

    task automatic t_error;
        int base;
        err_on = 1'b1;
        err_at = 8'h94;
        setcfg(1, 2'd1, 32'h00, 32'h90, 16'd6, 2'd0, 2'd0, 0, 0, 0, 1);
        fire(2'b10);
        wait_idle(1);
        chk("R9 write err flag", err_irq[1], 1);
        chk("R9 write err addr", err_addr[1], 32'h94);
        chk("R9 write err dir", err_dir[1], 1);
        chk("R9 failed element not counted", cur_cnt[1], 2);
        chk("R9 no completion", done_irq[1], 0);
        clr(1);
        chk("R9 err cleared", err_irq[1], 0);
        err_at = 8'hA0;
        base = log_n;
        setcfg(1, 2'd1, 32'hA0, 32'hA8, 16'd2, 2'd0, 2'd0, 0, 0, 0, 1);
        fire(2'b10);
        wait_idle(1);
        chk("R9 read err addr", err_addr[1], 32'hA0);
        chk("R9 read err dir", err_dir[1], 0);
        chk("R9 read err no write", log_n - base, 0);
        clr(1);
        err_on = 1'b0;
    endtask

    task automatic t_reload;
        int base = log_n;
        logic [7:0] exp [5] = '{8'hC0, 8'hC1, 8'hC0, 8'hC1, 8'hC0};
        int bad = 0;
        setcfg(0, 2'd1, 32'h00, 32'hC0, 16'd2, 2'd0, 2'd0, 0, 0, 1, 1);
        fire(2'b01);
        wait_log(base + 5);
        chk("R8 still busy after wrap", busy[0], 1);
        chk("R8 completion flagged", done_irq[0], 1);
        for (int k = 0; k < 5; k++) if (log_addr[base + k] != exp[k]) bad++;
        chk("R8 reload address pattern", bad, 0);
        command(0, 2'd3);
        wait_idle(0);
        clr(0);
    endtask

    task automatic t_cancel;
        int base = log_n;
        setcfg(0, 2'd1, 32'h00, 32'hD0, 16'd20, 2'd0, 2'd0, 0, 0, 0, 1);
        fire(2'b01);
        wait_log(base + 3);
        command(0, 2'd3);
        repeat (10) @(negedge clk);
        chk("R6 busy cleared", busy[0], 0);
        chk("R6 no completion", done_irq[0], 0);
        chk("R6 count left over", cur_cnt[0] != 0, 1);
        chk("R6 bus quiet", mem_req, 0);
    endtask

    task automatic t_pause;
        int base = log_n;
        int bad = 0;
        logic [15:0] c0;
        logic [31:0] s0;
        setcfg(1, 2'd1, 32'h00, 32'hE0, 16'd8, 2'd0, 2'd0, 0, 0, 0, 1);
        fire(2'b10);
        wait_log(base + 2);
        command(1, 2'd2);
        repeat (8) @(negedge clk);
        c0 = cur_cnt[1];
        s0 = cur_src[1];
        repeat (20) @(negedge clk);
        chk("R5 count held", cur_cnt[1], c0);
        chk("R5 src held", cur_src[1], s0);
        chk("R5 busy while paused", busy[1], 1);
        chk("R5 no bus traffic", mem_req, 0);
        setcfg(1, 2'd1, 32'h55, 32'h55, 16'd1, 2'd0, 2'd0, 0, 0, 0, 1);
        fire(2'b10);
        wait_idle(1);
        for (int k = 0; k < 8; k++) if (mem[8'hE0 + k] != mem[k]) bad++;
        chk("R5 resume completes copy", bad, 0);
        chk("R5 resume completion", done_irq[1], 1);
        clr(1);
    endtask

    task automatic t_prio;
        int base = log_n;
        int bad = 0;
        logic [7:0] exp [12] = '{8'h80, 8'h81, 8'h82, 8'h83, 8'h40, 8'h41,
                                 8'h42, 8'h43, 8'h44, 8'h45, 8'h84, 8'h85};
        setcfg(1, 2'd1, 32'h10, 32'h80, 16'd6, 2'd0, 2'd1, 0, 0, 0, 0);
        fire(2'b10);
        setcfg(0, 2'd1, 32'h00, 32'h40, 16'd6, 2'd0, 2'd1, 0, 0, 0, 0);
        fire(2'b01);
        wait_idle(0);
        wait_idle(1);
        chk("R10 write count", log_n - base, 12);
        for (int k = 0; k < 12; k++) if (log_addr[base + k] != exp[k]) bad++;
        chk("R10 grant order", bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_widths();
        t_fixed();
        t_zero();
        t_error();
        t_reload();
        t_cancel();
        t_pause();
        t_prio();
        chk("R12 request held until ack", hs_bad, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule